// File: doc/BRIEF.md
# USB Start-of-Frame Timer and Token Generator

This block paces USB frames for a host controller and produces the start-of-frame token for each one. A counter advances on every bit-clock tick and restarts when it reaches a 16-bit interval. Software supplies that interval as two byte-wide register values. Each restart produces a one-cycle frame-start pulse. It also advances an 11-bit frame number, and the hardware computes the CRC5 for the new number. Firmware takes no part in either step.

Tokens go to a downstream serialiser through a valid/ready handshake. A token is produced only when automatic SOF output is enabled and the host channel is armed. A forced bus reset (SE0) or suspend blocks the token, and so does a manual token that firmware has queued on the normal token path. The frame timing and numbering keep running in every one of these cases. Software can therefore read a correct frame number at any time. Enabling is expected to follow the programming of the interval.

Top module: `sof_frame_gen`

## Requirements
- R1: After an asynchronous reset, frame_start_o is 0, frame_num_o is 0 and tok_valid_o is 0.
- R2: The interval is {interval_hi_i, interval_lo_i}. On each cycle with bit_tick_i high, the counter increments. When the tick arrives with the count at or above the interval, the counter instead returns to 0. On that wrapping tick, frame_start_o goes high for exactly the following cycle. Frames are therefore interval+1 ticks long.
- R3: frame_num_o increments by one in the cycle after frame_start_o, and wraps from 2047 to 0. It changes at no other time.
- R4: A token carries tok_pid_o = 8'hA5, the new frame number in tok_frame_o, and the inverted CRC5 of that frame number in tok_crc_o. The CRC uses polynomial x^5+x^2+1 with an all-ones start value, and frame bit 0 is processed first. The serialiser sends the PID first, then the frame number, then the CRC. Each field goes out bit 0 first.
- R5: A token is created at a frame-start pulse only if sof_en_i and arm_i are both 1. While either of them is 0, tok_valid_o is 0 and any pending token is dropped. Frame numbering continues regardless.
- R6: While bus_reset_i or suspend_i is 1, tok_valid_o is 0 and any pending token is dropped. The interval counter and frame number keep advancing during this time.
- R7: A pending token stays pending, and its fields stay unchanged, until a cycle in which tok_valid_o and tok_ready_i are both high.
- R8: A frame-start pulse that arrives while a token is still pending replaces that token's fields with those of the new frame. The second token is not queued behind the first.
- R9: While manual_pending_i is 1, tok_valid_o is 0. The pending token is kept, and it is offered again once manual_pending_i returns to 0.
- R10: If the interval is lowered below the current count, the next tick wraps the counter and starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | Single-cycle bit-time strobe that advances the interval counter |
| interval_lo_i | input | 8 | Interval, low byte |
| interval_hi_i | input | 8 | Interval, high byte |
| sof_en_i | input | 1 | Enable for automatic SOF token output |
| arm_i | input | 1 | Host channel arm bit |
| bus_reset_i | input | 1 | Forced SE0 bus reset in progress |
| suspend_i | input | 1 | Suspend active |
| manual_pending_i | input | 1 | A firmware-issued token is waiting on the normal token path |
| tok_ready_i | input | 1 | Serialiser accepts the token |
| tok_valid_o | output | 1 | SOF token offered |
| tok_pid_o | output | 8 | Token PID (A5h) |
| tok_frame_o | output | 11 | Frame number carried in the token |
| tok_crc_o | output | 5 | Inverted CRC5 of tok_frame_o |
| frame_start_o | output | 1 | One-cycle frame boundary pulse |
| frame_num_o | output | 11 | Current frame number, for readback |

## Verification
The assertions assume that the interval bytes, enable, arm, reset, suspend and manual-pending inputs change only between clock edges. They also assume that tok_ready_i does not depend on anything other than the serialiser's own state. The bench drives every input shortly after the rising edge and compares outputs at the falling edge against a behavioural model. This keeps stimulus and observation apart. Ticks, ready and manual-pending are randomised within each phase. Interval changes are made while the counter is running, so the lowering case is exercised as well.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int unsigned FRAME_W = 11;
  localparam int unsigned CRC_W   = 5;
  localparam int unsigned IVL_W   = 16;
  localparam int unsigned PID_W   = 8;
  localparam logic [PID_W-1:0] PID_SOF  = 8'hA5;
  localparam logic [CRC_W-1:0] CRC5_POLY = 5'b00101;
endpackage

// File: rtl/sof_interval_timer.sv
module sof_interval_timer #(
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             frame_start_o
);
  logic [IVL_W-1:0] cnt_q;
  logic             wrap;

  // >= so that lowering the interval below the count wraps at once
  assign wrap = tick_i && (cnt_q >= interval_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= wrap;
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  a_r2_start_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !frame_start_o);
  a_r2_count_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> cnt_q == '0);
endmodule

// File: rtl/sof_crc5.sv
module sof_crc5 #(
  parameter int unsigned DATA_W = 11,
  parameter int unsigned CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'b00101
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = '1;
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = data_i[i] ^ stage[i][CRC_W-1];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
  assign crc_o = ~stage[DATA_W];
endmodule

// File: rtl/sof_token_slot.sv
module sof_token_slot #(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned CRC_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CRC_W-1:0]   crc_i,
  input  logic               emit_ok_i,
  input  logic               yield_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CRC_W-1:0]   crc_o
);
  logic pend_q;

  assign valid_o = pend_q && emit_ok_i && !yield_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      frame_o <= '0;
      crc_o   <= '0;
    end else begin
      if (!emit_ok_i)             pend_q <= 1'b0;
      else if (load_i)            pend_q <= 1'b1;  // overwrite, no queue
      else if (valid_o && ready_i) pend_q <= 1'b0;
      if (emit_ok_i && load_i) begin
        frame_o <= frame_i;
        crc_o   <= crc_i;
      end
    end
  end

  a_r7_hold_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !load_i |=> $stable(frame_o) && $stable(crc_o));
  a_r7_hold_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && emit_ok_i |=> pend_q || !emit_ok_i);
  a_r9_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    yield_i |-> !valid_o);
endmodule

// File: rtl/sof_frame_gen.sv
module sof_frame_gen
  import sof_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic [7:0]         interval_lo_i,
  input  logic [7:0]         interval_hi_i,
  input  logic               sof_en_i,
  input  logic               arm_i,
  input  logic               bus_reset_i,
  input  logic               suspend_i,
  input  logic               manual_pending_i,
  input  logic               tok_ready_i,
  output logic               tok_valid_o,
  output logic [PID_W-1:0]   tok_pid_o,
  output logic [FRAME_W-1:0] tok_frame_o,
  output logic [CRC_W-1:0]   tok_crc_o,
  output logic               frame_start_o,
  output logic [FRAME_W-1:0] frame_num_o
);
  logic [FRAME_W-1:0] frame_q, frame_next;
  logic [CRC_W-1:0]   crc_next;
  logic               emit_ok;

  sof_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (bit_tick_i),
    .interval_i   ({interval_hi_i, interval_lo_i}),
    .frame_start_o(frame_start_o)
  );

  assign frame_next = frame_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            frame_q <= '0;
    else if (frame_start_o) frame_q <= frame_next;
  end
  assign frame_num_o = frame_q;

  sof_crc5 #(.DATA_W(FRAME_W), .CRC_W(CRC_W), .POLY(CRC5_POLY)) u_crc (
    .data_i(frame_next),
    .crc_o (crc_next)
  );

  assign emit_ok = sof_en_i && arm_i && !bus_reset_i && !suspend_i;

  sof_token_slot #(.FRAME_W(FRAME_W), .CRC_W(CRC_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (frame_start_o),
    .frame_i  (frame_next),
    .crc_i    (crc_next),
    .emit_ok_i(emit_ok),
    .yield_i  (manual_pending_i),
    .ready_i  (tok_ready_i),
    .valid_o  (tok_valid_o),
    .frame_o  (tok_frame_o),
    .crc_o    (tok_crc_o)
  );

  assign tok_pid_o = PID_SOF;

  a_r3_frame_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> frame_num_o == $past(frame_num_o) + 1'b1);
  a_r3_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |=> $stable(frame_num_o));
  a_r5_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sof_en_i && arm_i) |-> !tok_valid_o);
  a_r6_line_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i || suspend_i) |-> !tok_valid_o);
endmodule

// File: tb/sof_frame_gen_tb_top.sv
module sof_frame_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, en = 0, arm = 0, brst = 0, susp = 0, man = 0, ready = 0;
  logic [15:0] intv = 16'd5;
  logic        valid, fs;
  logic [7:0]  pid;
  logic [10:0] tfrm, fnum;
  logic [4:0]  tcrc;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_fn = 0, m_tfn = 0, accepted = 0, overwrites = 0, wraps = 0;
  bit m_fs = 0, m_pend = 0, done = 0;

  always #4 clk = ~clk;

  sof_frame_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick),
    .interval_lo_i(intv[7:0]), .interval_hi_i(intv[15:8]),
    .sof_en_i(en), .arm_i(arm), .bus_reset_i(brst), .suspend_i(susp),
    .manual_pending_i(man), .tok_ready_i(ready),
    .tok_valid_o(valid), .tok_pid_o(pid), .tok_frame_o(tfrm), .tok_crc_o(tcrc),
    .frame_start_o(fs), .frame_num_o(fnum)
  );

  function automatic int ref_crc(int f);
    int r = 31;
    for (int i = 0; i < 11; i++) begin
      int top = (r >> 4) & 1;
      r = (r << 1) & 31;
      if ((((f >> i) & 1) ^ top) != 0) r = r ^ 5;
    end
    return (~r) & 31;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit emit_ok();
    return en && arm && !brst && !susp;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit wrap, n_fs, n_pend, exp_v;
      int n_cnt, n_fn, n_tfn;
      wrap   = tick && (m_cnt >= int'(intv));
      n_cnt  = tick ? (wrap ? 0 : m_cnt + 1) : m_cnt;
      n_fs   = wrap;
      n_fn   = m_fs ? (m_fn + 1) % 2048 : m_fn;
      if (m_fs && m_fn == 2047) wraps++;
      exp_v  = m_pend && emit_ok() && !man;
      n_pend = m_pend;
      n_tfn  = m_tfn;
      if (!emit_ok()) n_pend = 0;
      else if (m_fs) begin
        if (m_pend) overwrites++;
        n_pend = 1;
        n_tfn  = (m_fn + 1) % 2048;
      end else if (exp_v && ready) begin
        n_pend = 0;
        accepted++;
      end
      m_cnt = n_cnt; m_fs = n_fs; m_fn = n_fn; m_pend = n_pend; m_tfn = n_tfn;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_v;
      exp_v = m_pend && emit_ok() && !man;
      check(fs == m_fs, "R2 frame_start", fs, m_fs);
      check(int'(fnum) == m_fn, "R3 frame_num", fnum, m_fn);
      check(valid == exp_v, "R5/R6/R9 tok_valid", valid, exp_v);
      if (exp_v) begin
        check(int'(tfrm) == m_tfn, "R7/R8 tok_frame", tfrm, m_tfn);
        check(int'(tcrc) == ref_crc(m_tfn), "R4 tok_crc", tcrc, ref_crc(m_tfn));
        check(pid == 8'hA5, "R4 tok_pid", pid, 8'hA5);
      end
    end
  end

  task automatic run(int n, int tick_pct, int rdy_pct, int man_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick  = ($urandom % 100) < tick_pct;
      ready = ($urandom % 100) < rdy_pct;
      man   = ($urandom % 100) < man_pct;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    check(fs == 0, "R1 reset frame_start", fs, 0);
    check(fnum == 0, "R1 reset frame_num", fnum, 0);
    check(valid == 0, "R1 reset tok_valid", valid, 0);
    #20; @(posedge clk); #1; rst_n = 1;
    // R5: counting runs with output disabled
    intv = 16'd5;
    run(200, 100, 100, 0);
    check(fnum != 0, "R5 numbering continues while disabled", fnum, 1);
    // R4/R7: enabled, varied ready
    en = 1; arm = 1;
    run(400, 100, 100, 0);
    run(600, 80, 30, 0);
    // R8: stalled serialiser so boundaries overwrite
    run(300, 100, 0, 0);
    // R9: manual token contention
    run(500, 100, 60, 40);
    // R6: bus reset then suspend
    brst = 1; run(200, 100, 100, 0); brst = 0;
    run(100, 100, 100, 0);
    susp = 1; run(200, 100, 100, 0); susp = 0;
    arm = 0; run(100, 100, 100, 0); arm = 1;
    // R10: lower interval mid-count
    intv = 16'd300; run(150, 100, 100, 0);
    intv = 16'd3;   run(50, 100, 100, 0);
    // R3: wrap 2047 -> 0 at interval 0
    intv = 16'd0; run(2200, 100, 70, 10);
    intv = 16'd9; run(500, 50, 50, 10);
    @(negedge clk);
    check(wraps > 0, "R3 frame wrap observed", wraps, 1);
    check(overwrites > 0, "R8 overwrite observed", overwrites, 1);
    check(accepted > 0, "R4 tokens accepted", accepted, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule